// File: doc/BRIEF.md
# Distributed Parallel-Request Bus Arbiter

This block shares one bus among a set of devices without a central arbiter. Each device has a dedicated request line with a fixed rank. Every device watches the full set of lines, not just its own. A device that wants the bus raises its line and keeps it high for as long as it is asking. When a bus cycle ends, each device decides for itself whether it is the highest-ranked active requester. The one that is takes the bus for the following cycle.

The design has one arbitration node per device and a wrapper. The wrapper ties all the nodes to a shared request vector and keeps a flag showing whether the bus has an owner. A strobe input marks the end of each bus cycle. Grants and the owner flag change only on that strobe and hold steady in between. The number of devices cannot exceed the number of request lines; the wrapper refuses such a configuration when it is elaborated. A parameter chooses how each node detects a higher-ranked request: a scanning loop, or a single masked reduction.

Top module: `dpr_bus_arbiter`

## Requirements
- R1: While rst_n is low, and after reset until the first strobe, every bit of dev_grant is 0 and bus_owned is 0.
- R2: In the same cycle, bit i of req_lines equals dev_want[i] for every device i. Lines with an index at or above NUM_DEV stay at 0.
- R3: On a clock edge where cycle_end is 1, the grant goes to the device with the lowest index among those whose dev_want bit is 1. Line 0 has the highest rank. That device's dev_grant bit is 1 from the following cycle on.
- R4: On an edge where cycle_end is 0, dev_grant and bus_owned keep their values, whatever dev_want does.
- R5: On a strobe edge where no dev_want bit is 1, every dev_grant bit goes to 0 and bus_owned goes to 0 for the next cycle.
- R6: At no time is more than one dev_grant bit 1.
- R7: bus_owned is 1 exactly when some dev_grant bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_end | input | 1 | Strobe marking the end of a bus cycle; the decision boundary |
| dev_want | input | NUM_DEV | Per-device bus request from local logic |
| req_lines | output | NUM_LINES | Shared request vector driven by the nodes |
| dev_grant | output | NUM_DEV | Per-device ownership for the current bus cycle |
| bus_owned | output | 1 | High while some device owns the bus |

## Verification
A strobe edge can coincide with a change in the request pattern, and that coincidence is the main stress on the block. The bench changes dev_want in the same cycle that cycle_end is high. It also raises the strobe on two cycles in a row with different patterns. This checks that each decision uses only the vector present at its own edge. After each decision the bench inverts the pattern with the strobe low, which checks that the grant stays put. Expected grants are the lowest set bit of the sampled pattern, computed arithmetically, for every pattern of a five-device configuration.

// File: rtl/dpr_arb_pkg.sv
package dpr_arb_pkg;

   // How a node detects a request of higher rank than its own
   typedef enum logic [0:0] {
      DEC_LOOP = 1'b0,   // scan lower-indexed lines one by one
      DEC_MASK = 1'b1    // AND with a constant mask, then reduce
   } dec_style_e;

endpackage

// File: rtl/dpr_arb_node.sv
module dpr_arb_node
   import dpr_arb_pkg::*;
#(
   parameter int         NUM_LINES = 16,
   parameter int         MY_IDX    = 0,
   parameter dec_style_e STYLE     = DEC_MASK
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cycle_end,
   input  logic                 want,
   input  logic [NUM_LINES-1:0] req_vec,
   output logic                 req_out,
   output logic                 grant
);

   logic higher_busy;
   logic win;

   // A node drives its own line for as long as local logic asks
   assign req_out = want;

   generate
      if (STYLE == DEC_LOOP) begin : g_loop
         always_comb begin
            higher_busy = 1'b0;
            for (int j = 0; j < MY_IDX; j++) begin
               higher_busy = higher_busy | req_vec[j];
            end
         end
      end else begin : g_mask
         localparam logic [NUM_LINES-1:0] HI_MASK =
            (NUM_LINES'(1) << MY_IDX) - NUM_LINES'(1);
         assign higher_busy = |(req_vec & HI_MASK);
      end
   endgenerate

   // Decision reads the shared line, not the local wish
   assign win = req_vec[MY_IDX] & ~higher_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant <= 1'b0;
      end else if (cycle_end) begin
         grant <= win;
      end
   end

endmodule

// File: rtl/dpr_owner_flag.sv
module dpr_owner_flag #(
   parameter int NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cycle_end,
   input  logic [NUM_LINES-1:0] req_vec,
   output logic                 owned
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owned <= 1'b0;
      end else if (cycle_end) begin
         owned <= |req_vec;
      end
   end

endmodule

// File: rtl/dpr_bus_arbiter.sv
module dpr_bus_arbiter
   import dpr_arb_pkg::*;
#(
   parameter int         NUM_LINES = 16,
   parameter int         NUM_DEV   = 16,
   parameter dec_style_e STYLE     = DEC_MASK
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cycle_end,
   input  logic [NUM_DEV-1:0]   dev_want,
   output logic [NUM_LINES-1:0] req_lines,
   output logic [NUM_DEV-1:0]   dev_grant,
   output logic                 bus_owned
);

   localparam int SPARE = NUM_LINES - NUM_DEV;

   generate
      if (NUM_DEV < 1) begin : g_bad_dev
         $error("dpr_bus_arbiter: NUM_DEV must be at least 1");
      end
      if (NUM_DEV > NUM_LINES) begin : g_bad_fit
         $error("dpr_bus_arbiter: NUM_DEV exceeds NUM_LINES");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_DEV; gi++) begin : g_node
         dpr_arb_node #(
            .NUM_LINES (NUM_LINES),
            .MY_IDX    (gi),
            .STYLE     (STYLE)
         ) u_node (
            .clk       (clk),
            .rst_n     (rst_n),
            .cycle_end (cycle_end),
            .want      (dev_want[gi]),
            .req_vec   (req_lines),
            .req_out   (req_lines[gi]),
            .grant     (dev_grant[gi])
         );
      end
      if (SPARE > 0) begin : g_spare
         assign req_lines[NUM_LINES-1:NUM_DEV] = '0;
      end
   endgenerate

   dpr_owner_flag #(
      .NUM_LINES (NUM_LINES)
   ) u_owner (
      .clk       (clk),
      .rst_n     (rst_n),
      .cycle_end (cycle_end),
      .req_vec   (req_lines),
      .owned     (bus_owned)
   );

endmodule

// File: rtl/dpr_bus_arbiter_chk.sv
module dpr_bus_arbiter_chk #(
   parameter int NUM_LINES = 16,
   parameter int NUM_DEV   = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cycle_end,
   input logic [NUM_DEV-1:0]   dev_want,
   input logic [NUM_LINES-1:0] req_lines,
   input logic [NUM_DEV-1:0]   dev_grant,
   input logic                 bus_owned
);

   logic [NUM_LINES-1:0] want_ext;
   logic [NUM_DEV-1:0]   lowest_want;

   always_comb begin
      want_ext = '0;
      want_ext[NUM_DEV-1:0] = dev_want;
   end

   assign lowest_want = dev_want & (~dev_want + NUM_DEV'(1));

   a_r2_lines_follow: assert property (@(posedge clk) disable iff (!rst_n)
      req_lines == want_ext);

   a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> dev_grant == $past(lowest_want));

   a_r4_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(dev_grant) && $stable(bus_owned));

   a_r5_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_end && dev_want == '0) |=> (dev_grant == '0) && !bus_owned);

   a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_grant));

   a_r7_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
      bus_owned == (|dev_grant));

endmodule

bind dpr_bus_arbiter dpr_bus_arbiter_chk #(
   .NUM_LINES (NUM_LINES),
   .NUM_DEV   (NUM_DEV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cycle_end (cycle_end),
   .dev_want  (dev_want),
   .req_lines (req_lines),
   .dev_grant (dev_grant),
   .bus_owned (bus_owned)
);

// File: tb/dpr_bus_arbiter_bench.sv
module dpr_bus_arbiter_bench;
   import dpr_arb_pkg::*;

   localparam int NL = 6;
   localparam int ND = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cycle_end = 1'b0;
   logic [ND-1:0] dev_want = '0;
   logic [NL-1:0] req_lines;
   logic [ND-1:0] dev_grant;
   logic          bus_owned;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;   // 50 MHz

   dpr_bus_arbiter #(
      .NUM_LINES (NL),
      .NUM_DEV   (ND),
      .STYLE     (DEC_LOOP)
   ) u_dpr_bus_arbiter (
      .clk       (clk),
      .rst_n     (rst_n),
      .cycle_end (cycle_end),
      .dev_want  (dev_want),
      .req_lines (req_lines),
      .dev_grant (dev_grant),
      .bus_owned (bus_owned)
   );

   function automatic logic [ND-1:0] low_bit(input logic [ND-1:0] p);
      return p & (~p + ND'(1));
   endfunction

   task automatic chk(input string req, input logic [NL-1:0] act,
                      input logic [NL-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // Strobe with pattern p, then check grant and owner flag
   task automatic strobe_and_check(input logic [ND-1:0] p, input string tag);
      logic [ND-1:0] g;
      dev_want  = p;
      cycle_end = 1'b1;
      #1;
      chk("R2 lines follow want", req_lines, NL'(p));
      @(negedge clk);
      cycle_end = 1'b0;
      g = low_bit(p);
      chk({"R3 lowest index wins ", tag}, NL'(dev_grant), NL'(g));
      chk("R5/R7 owner flag", NL'(bus_owned), NL'(p != '0));
      chk("R6 at most one grant", NL'($countones(dev_grant) <= 1), NL'(1));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset grant", NL'(dev_grant), '0);
      chk("R1 reset owner", NL'(bus_owned), '0);
      rst_n = 1'b1;
      dev_want = 5'b10110;
      @(negedge clk);
      chk("R1 no grant before first strobe", NL'(dev_grant), '0);
      chk("R2 spare lines zero", NL'(req_lines[NL-1:ND]), '0);

      // Sweep every pattern; then invert want with strobe low
      for (int p = 0; p < (1 << ND); p++) begin
         logic [ND-1:0] g;
         strobe_and_check(ND'(p), "sweep");
         g = low_bit(ND'(p));
         dev_want = ~ND'(p);
         @(negedge clk);
         chk("R4 grant held without strobe", NL'(dev_grant), NL'(g));
         chk("R4 owner held without strobe", NL'(bus_owned), NL'(p != 0));
      end

      // Back-to-back strobes with different patterns each edge
      for (int p = 1; p < (1 << ND); p++) begin
         strobe_and_check(ND'(p), "first");
         strobe_and_check({<<{ND'(p)}}, "second");
      end

      // Busy then idle boundary
      strobe_and_check(5'b10000, "top only");
      strobe_and_check(5'b00000, "R5 idle");

      finish_run();
   end

endmodule